// File: doc/BRIEF.md
# Buffered PWM Timer with Trigger-Driven Reload

A 16-bit timer with a single channel. Software writes a modulo (terminal count) value, a start-count value and a compare value into holding buffers. The counter and the channel use separate active copies of these values. The channel runs in one of three modes: output compare, edge-aligned PWM or center-aligned PWM. Each mode has its own boundary point where the buffers are copied into the active set. A power-of-two prescaler sets how fast the counter advances.

Three external trigger lines can start a reload event. Each line has its own enable bit. A reload copies all three buffers into the active set and sends the counter back to the start count. When the sync-only control bit is set, the normal boundary copies are suppressed, so buffered values take effect only on a reload event. When the hold bit is clear, a trigger enable clears itself after it fires.

The register write port is a valid/ready stream. `wr_ready` is held high at all times, so a write completes in every cycle where `wr_valid` is high and the block never applies back-pressure.

Top module: `pwm_sync_timer`

## Requirements
- R1: After reset, `count`, `cmp_active`, `pwm_out`, `match_pulse` and `trig_en` are all zero, and `wr_ready` is 1.
- R2: With prescale field N, the counter moves one step every 2^N clock cycles. The prescaler restarts on a reload event, so the first step after a reload comes 2^N cycles later.
- R3: In edge-aligned mode (mode code 1) the counter counts up from the start count to the modulo value and then returns to the start count. In either PWM mode, `pwm_out` equals (`count` < `cmp_active`).
- R4: In center-aligned mode (mode code 2) the counter counts up from the start count to the modulo value, steps down to the start count, and then counts up again.
- R5: In edge-aligned mode, buffered values become active on the step from the modulo value back to the start count, and at no other step.
- R6: With the free-run bit set in edge-aligned mode, the modulo value is ignored. The counter wraps from 0xFFFF to 0x0000, and buffered values become active on that wrap.
- R7: In center-aligned mode, buffered values become active on the step from the modulo value down to modulo minus 1. They are not loaded at the turn at the start count.
- R8: In output compare mode (mode code 0), a buffered value becomes active at the next counter step.
- R9: In output compare mode, the step at which the counter reaches the active compare value toggles `pwm_out` and raises `match_pulse` for exactly one cycle.
- R10: A rising edge on `trig_in[i]` with `trig_en[i]` set acts three clock edges after the input changes. It sets `count` to the buffered start count and loads all three buffers into the active set. This reload takes priority over a boundary load in the same cycle. An edge on a line whose enable is clear has no effect.
- R11: With the sync-only bit set, no boundary load occurs. The active values change only on a reload event.
- R12: With the hold bit clear, `trig_en[i]` clears itself when line i fires. With the hold bit set, it stays set. A write to the enable register replaces all enable bits.
- R13: Register map, selected by `wr_addr`:
  - 0: modulo buffer.
  - 1: start-count buffer.
  - 2: compare buffer.
  - 3: control register, with these fields:
    - bits 1:0: mode.
    - bits 4:2: prescale N.
    - bit 5: sync-only.
    - bit 6: hold.
    - bit 7: run.
    - bit 8: free-run.
  - 4: trigger enables, in bits 2:0.

  A write takes effect at the clock edge where `wr_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Register write request |
| wr_ready | output | 1 | Write accepted; always 1 |
| wr_addr | input | 3 | Register select |
| wr_data | input | 16 | Write data |
| trig_in | input | 3 | External trigger lines, asynchronous |
| trig_en | output | 3 | Current trigger enable bits |
| count | output | 16 | Counter value |
| cmp_active | output | 16 | Active compare value |
| pwm_out | output | 1 | Channel output |
| match_pulse | output | 1 | One-cycle output compare match flag |

## Verification
A register write is visible one edge after it is presented. A trigger change shows up in `count` and `cmp_active` at the third rising edge after the change. With prescale N, counter steps fall 2^N edges apart, counted from the reload. The bench drives inputs and samples outputs on the falling edge. It computes each expected count as the start count plus the number of elapsed edges shifted right by N, taken modulo the period. Load-point checks sample the cycle in which the counter sits on the boundary value, then the cycle just after it, so an early load and a late load both fail.

// File: rtl/pwm_sync_pkg.sv
package pwm_sync_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_MOD  = 3'd0;
  localparam logic [ADDR_W-1:0] A_INIT = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMP  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CTL  = 3'd3;
  localparam logic [ADDR_W-1:0] A_TRIG = 3'd4;
  localparam int N_BUF = 3;

  typedef enum logic [1:0] {
    MODE_OC     = 2'd0,
    MODE_EDGE   = 2'd1,
    MODE_CENTER = 2'd2,
    MODE_RSVD   = 2'd3
  } mode_e;

  typedef struct packed {
    logic       free_run;
    logic       run;
    logic       hold;
    logic       sync_only;
    logic [2:0] pre_sel;
    mode_e      mode;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);
endpackage

// File: rtl/pst_trigger.sv
module pst_trigger #(
  parameter int N_TRIG = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_TRIG-1:0] trig_in,
  input  logic              en_wr,
  input  logic [N_TRIG-1:0] en_wdata,
  input  logic              hold,
  output logic [N_TRIG-1:0] en,
  output logic [N_TRIG-1:0] edge_hit,
  output logic              sync_evt
);
  logic [N_TRIG-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= trig_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign edge_hit = s2_q & ~s3_q & en;
  assign sync_evt = |edge_hit;

  for (genvar i = 0; i < N_TRIG; i++) begin : g_en
    logic en_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   en_q <= 1'b0;
      else if (en_wr)               en_q <= en_wdata[i];
      else if (!hold && edge_hit[i]) en_q <= 1'b0;
    end
    assign en[i] = en_q;
  end
endmodule

// File: rtl/pst_regs.sv
module pst_regs
  import pwm_sync_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic              load,
  output ctl_t              ctl,
  output logic [W-1:0]      init_buf,
  output logic [W-1:0]      cmp_buf,
  output logic [W-1:0]      mod_act,
  output logic [W-1:0]      init_act,
  output logic [W-1:0]      cmp_act,
  output logic [W-1:0]      init_nx,
  output logic [W-1:0]      cmp_nx
);
  logic [W-1:0] buf_q [N_BUF];
  logic [W-1:0] act_q [N_BUF];
  logic [W-1:0] nx    [N_BUF];

  for (genvar i = 0; i < N_BUF; i++) begin : g_pair
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        buf_q[i] <= '0;
        act_q[i] <= '0;
      end else begin
        if (wr_fire && wr_addr == ADDR_W'(i)) buf_q[i] <= wr_data;
        act_q[i] <= nx[i];
      end
    end
    assign nx[i] = load ? buf_q[i] : act_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         ctl <= '0;
    else if (wr_fire && wr_addr == A_CTL) ctl <= ctl_t'(wr_data[CTL_W-1:0]);
  end

  assign init_buf = buf_q[A_INIT];
  assign cmp_buf  = buf_q[A_CMP];
  assign mod_act  = act_q[A_MOD];
  assign init_act = act_q[A_INIT];
  assign cmp_act  = act_q[A_CMP];
  assign init_nx  = nx[A_INIT];
  assign cmp_nx   = nx[A_CMP];
endmodule

// File: rtl/pst_counter.sv
module pst_counter
  import pwm_sync_pkg::*;
#(
  parameter int W    = 16,
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [PS_W-1:0] pre_sel,
  input  mode_e           mode,
  input  logic            free_run,
  input  logic            sync,
  input  logic [W-1:0]    mod_act,
  input  logic [W-1:0]    init_act,
  input  logic [W-1:0]    init_nx,
  output logic [W-1:0]    count,
  output logic [W-1:0]    count_nx,
  output logic            tick,
  output logic            boundary
);
  localparam int PRE_W = (1 << PS_W) - 1;

  logic [PRE_W-1:0] pre_q, pre_mask;
  logic             up_q, up_nx;
  logic [W-1:0]     top;

  assign pre_mask = ~({PRE_W{1'b1}} << pre_sel);
  assign tick     = run && ((pre_q & pre_mask) == pre_mask);
  assign top      = free_run ? {W{1'b1}} : mod_act;

  // Load point: does not read init_nx, so no loop through the register bank.
  always_comb begin
    boundary = 1'b0;
    if (tick) begin
      case (mode)
        MODE_CENTER: boundary = up_q && (count == mod_act);
        MODE_EDGE:   boundary = (count == top);
        default:     boundary = 1'b1;
      endcase
    end
  end

  always_comb begin
    count_nx = count;
    up_nx    = up_q;
    if (sync) begin
      count_nx = init_nx;
      up_nx    = 1'b1;
    end else if (tick) begin
      if (mode == MODE_CENTER) begin
        if (up_q) begin
          if (count == mod_act) begin
            up_nx    = 1'b0;
            count_nx = count - 1'b1;
          end else begin
            count_nx = count + 1'b1;
          end
        end else begin
          if (count == init_act) begin
            up_nx    = 1'b1;
            count_nx = count + 1'b1;
          end else begin
            count_nx = count - 1'b1;
          end
        end
      end else begin
        if (count == top) count_nx = free_run ? '0 : init_nx;
        else              count_nx = count + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      up_q  <= 1'b1;
      pre_q <= '0;
    end else begin
      count <= count_nx;
      up_q  <= up_nx;
      if (sync)     pre_q <= '0;
      else if (run) pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/pst_channel.sv
module pst_channel
  import pwm_sync_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  mode_e        mode,
  input  logic         tick,
  input  logic         sync,
  input  logic [W-1:0] count_nx,
  input  logic [W-1:0] cmp_nx,
  output logic         pwm_out,
  output logic         match_pulse
);
  logic is_oc, hit;

  assign is_oc = !(mode == MODE_EDGE || mode == MODE_CENTER);
  assign hit   = tick && !sync && is_oc && (count_nx == cmp_nx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_out     <= 1'b0;
      match_pulse <= 1'b0;
    end else begin
      match_pulse <= hit;
      pwm_out     <= is_oc ? (pwm_out ^ hit) : (count_nx < cmp_nx);
    end
  end
endmodule

// File: rtl/pwm_sync_timer.sv
module pwm_sync_timer
  import pwm_sync_pkg::*;
#(
  parameter int W      = 16,
  parameter int N_TRIG = 3,
  parameter int PS_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic [N_TRIG-1:0] trig_in,
  output logic [N_TRIG-1:0] trig_en,
  output logic [W-1:0]      count,
  output logic [W-1:0]      cmp_active,
  output logic              pwm_out,
  output logic              match_pulse
);
  ctl_t              ctl;
  logic              wr_fire, trig_wr, sync_evt, tick, boundary, load;
  logic              pwm_mode, sync_only, trig_hold;
  logic [N_TRIG-1:0] edge_hit;
  logic [W-1:0]      init_buf, cmp_buf, mod_act, init_act, init_nx, cmp_nx, count_nx;

  assign wr_ready  = 1'b1;
  assign wr_fire   = wr_valid;
  assign trig_wr   = wr_fire && (wr_addr == A_TRIG);
  assign sync_only = ctl.sync_only;
  assign trig_hold = ctl.hold;
  assign pwm_mode  = (ctl.mode == MODE_EDGE) || (ctl.mode == MODE_CENTER);
  assign load      = sync_evt || (boundary && !ctl.sync_only);

  pst_trigger #(.N_TRIG(N_TRIG)) u_trig (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .en_wr(trig_wr),
    .en_wdata(wr_data[N_TRIG-1:0]), .hold(ctl.hold), .en(trig_en),
    .edge_hit(edge_hit), .sync_evt(sync_evt)
  );

  pst_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_addr(wr_addr),
    .wr_data(wr_data), .load(load), .ctl(ctl), .init_buf(init_buf),
    .cmp_buf(cmp_buf), .mod_act(mod_act), .init_act(init_act),
    .cmp_act(cmp_active), .init_nx(init_nx), .cmp_nx(cmp_nx)
  );

  pst_counter #(.W(W), .PS_W(PS_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(ctl.run), .pre_sel(ctl.pre_sel[PS_W-1:0]),
    .mode(ctl.mode), .free_run(ctl.free_run), .sync(sync_evt),
    .mod_act(mod_act), .init_act(init_act), .init_nx(init_nx),
    .count(count), .count_nx(count_nx), .tick(tick), .boundary(boundary)
  );

  pst_channel #(.W(W)) u_ch (
    .clk(clk), .rst_n(rst_n), .mode(ctl.mode), .tick(tick), .sync(sync_evt),
    .count_nx(count_nx), .cmp_nx(cmp_nx), .pwm_out(pwm_out),
    .match_pulse(match_pulse)
  );
endmodule

// File: rtl/pst_checker.sv
module pst_checker #(
  parameter int W      = 16,
  parameter int N_TRIG = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwm_mode,
  input logic              pwm_out,
  input logic              match_pulse,
  input logic              tick,
  input logic              sync_evt,
  input logic              sync_only,
  input logic              trig_hold,
  input logic              trig_wr,
  input logic [N_TRIG-1:0] trig_en,
  input logic [N_TRIG-1:0] edge_hit,
  input logic [W-1:0]      count,
  input logic [W-1:0]      cmp_active,
  input logic [W-1:0]      init_buf,
  input logic [W-1:0]      cmp_buf
);
  // R2: the counter holds between prescaler steps and reloads
  p_hold_between_steps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !sync_evt) |=> (count == $past(count)));

  // R3, R4: PWM level follows count against active compare
  p_pwm_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_mode |=> (pwm_out == (count < cmp_active)));

  // R9: every match flag comes with an output toggle
  p_match_toggles_r9: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> (pwm_out != $past(pwm_out)));

  // R10: reload forces start count and compare from the buffers
  p_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sync_evt |=> ((count == $past(init_buf)) && (cmp_active == $past(cmp_buf))));

  // R11: sync-only keeps the active compare still without a reload
  p_sync_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_only && !sync_evt) |=> (cmp_active == $past(cmp_active)));

  // R12: a fired enable clears itself when hold is off
  p_self_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_evt && !trig_hold && !trig_wr) |=> ((trig_en & $past(edge_hit)) == '0));
endmodule

bind pwm_sync_timer pst_checker #(.W(W), .N_TRIG(N_TRIG)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwm_mode(pwm_mode), .pwm_out(pwm_out),
  .match_pulse(match_pulse), .tick(tick), .sync_evt(sync_evt),
  .sync_only(sync_only), .trig_hold(trig_hold), .trig_wr(trig_wr),
  .trig_en(trig_en), .edge_hit(edge_hit), .count(count),
  .cmp_active(cmp_active), .init_buf(init_buf), .cmp_buf(cmp_buf)
);

// File: tb/pwm_sync_timer_test.sv
`timescale 1ns/1ps
module pwm_sync_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  trig_in = '0;
  logic [2:0]  trig_en;
  logic [15:0] count, cmp_active;
  logic        pwm_out, match_pulse;
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  pwm_sync_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .trig_in(trig_in), .trig_en(trig_en),
    .count(count), .cmp_active(cmp_active), .pwm_out(pwm_out),
    .match_pulse(match_pulse)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ctlw(input int mode, input int ps, input bit so,
                                       input bit hold, input bit fr);
    return {7'd0, fr, 1'b1, hold, so, ps[2:0], mode[1:0]};
  endfunction

  // starts and ends just after a falling edge; one rising edge inside
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic fire(input int i);
    trig_in[i] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setup(input int mode, input int ps, input bit so, input bit hold,
                       input int m, input int ini, input int c);
    wr(3'd0, 16'(m));
    wr(3'd1, 16'(ini));
    wr(3'd2, 16'(c));
    wr(3'd3, ctlw(mode, ps, so, hold, 1'b0));
    wr(3'd4, 16'd7);
    fire(0);
    chk(count == 16'(ini), "R10 reload count", int'(count), ini);
    chk(cmp_active == 16'(c), "R10 reload compare", int'(cmp_active), c);
    trig_in = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(count == 0, "R1 count", int'(count), 0);
    chk(cmp_active == 0, "R1 compare", int'(cmp_active), 0);
    chk(pwm_out == 0, "R1 pwm", int'(pwm_out), 0);
    chk(match_pulse == 0, "R1 match", int'(match_pulse), 0);
    chk(trig_en == 0, "R1 enables", int'(trig_en), 0);
    chk(wr_ready == 1, "R13 ready", int'(wr_ready), 1);

    // R2 R3 sweep: edge-aligned, M=6 I=2
    for (int ps = 0; ps < 4; ps++) begin
      for (int ci = 0; ci < 3; ci++) begin
        int c;
        c = (ci == 0) ? 2 : (ci == 1) ? 4 : 7;
        setup(1, ps, 0, 1, 6, 2, c);
        for (int n = 0; n <= (10 << ps); n++) begin
          int e;
          e = 2 + ((n >> ps) % 5);
          chk(int'(count) == e, "R2 R3 edge count", int'(count), e);
          chk(pwm_out == (e < c), "R3 edge pwm", int'(pwm_out), int'(e < c));
          @(negedge clk);
        end
      end
    end

    // R4 sweep: center-aligned, M=6 I=2, period 8 steps
    for (int ps = 0; ps < 3; ps++) begin
      for (int ci = 0; ci < 3; ci++) begin
        int c;
        c = (ci == 0) ? 3 : (ci == 1) ? 5 : 7;
        setup(2, ps, 0, 1, 6, 2, c);
        for (int n = 0; n <= (16 << ps); n++) begin
          int p, e;
          p = (n >> ps) % 8;
          e = (p <= 4) ? 2 + p : 10 - p;
          chk(int'(count) == e, "R4 center count", int'(count), e);
          chk(pwm_out == (e < c), "R3 center pwm", int'(pwm_out), int'(e < c));
          @(negedge clk);
        end
      end
    end

    // R5 edge load point
    setup(1, 0, 0, 1, 6, 1, 3);
    wr(3'd2, 16'd5);
    while (count != 16'd6) @(negedge clk);
    chk(cmp_active == 3, "R5 not before wrap", int'(cmp_active), 3);
    @(negedge clk);
    chk(count == 1, "R5 wrap count", int'(count), 1);
    chk(cmp_active == 5, "R5 loaded at wrap", int'(cmp_active), 5);

    // R7 center load point
    setup(2, 0, 0, 1, 6, 1, 3);
    wr(3'd2, 16'd5);
    while (count != 16'd6) @(negedge clk);
    chk(cmp_active == 3, "R7 not before top", int'(cmp_active), 3);
    @(negedge clk);
    chk(count == 5, "R7 step down", int'(count), 5);
    chk(cmp_active == 5, "R7 loaded at top", int'(cmp_active), 5);
    wr(3'd2, 16'd2);
    while (count != 16'd1) @(negedge clk);
    @(negedge clk);
    chk(count == 2, "R7 bottom turn", int'(count), 2);
    chk(cmp_active == 5, "R7 no load at bottom", int'(cmp_active), 5);
    while (count != 16'd6) @(negedge clk);
    @(negedge clk);
    chk(cmp_active == 2, "R7 second top load", int'(cmp_active), 2);

    // R6 free-run wrap
    setup(1, 0, 0, 1, 16'hFFFC, 16'hFFFA, 16'hFFFD);
    wr(3'd3, ctlw(1, 0, 0, 1, 1'b1));
    wr(3'd2, 16'd2);
    while (count != 16'hFFFF) @(negedge clk);
    chk(cmp_active == 16'hFFFD, "R6 not at modulo", int'(cmp_active), 16'hFFFD);
    @(negedge clk);
    chk(count == 0, "R6 wrap to zero", int'(count), 0);
    chk(cmp_active == 2, "R6 loaded at wrap", int'(cmp_active), 2);
    chk(pwm_out == 1, "R6 pwm after wrap", int'(pwm_out), 1);

    // R8 R9 output compare, prescale 4
    setup(0, 2, 0, 1, 20, 0, 5);
    begin
      logic p0;
      p0 = pwm_out;
      for (int n = 1; n <= 21; n++) begin
        @(negedge clk);
        if (n == 20) begin
          chk(count == 5, "R9 count at match", int'(count), 5);
          chk(match_pulse == 1, "R9 match raised", int'(match_pulse), 1);
          chk(pwm_out == !p0, "R9 toggled", int'(pwm_out), int'(!p0));
        end
        if (n == 21) chk(match_pulse == 0, "R9 one cycle", int'(match_pulse), 0);
      end
    end
    wr(3'd2, 16'd9);
    chk(cmp_active == 5, "R8 before step", int'(cmp_active), 5);
    repeat (3) @(negedge clk);
    chk(cmp_active == 9, "R8 at next step", int'(cmp_active), 9);

    // R11 sync-only
    setup(1, 0, 1, 1, 6, 1, 3);
    wr(3'd2, 16'd4);
    while (count != 16'd6) @(negedge clk);
    @(negedge clk);
    chk(count == 1, "R11 wrapped", int'(count), 1);
    chk(cmp_active == 3, "R11 no boundary load", int'(cmp_active), 3);
    while (count != 16'd3) @(negedge clk);
    fire(2);
    chk(count == 1, "R11 R10 reload line 2", int'(count), 1);
    chk(cmp_active == 4, "R11 loaded on reload", int'(cmp_active), 4);
    trig_in = '0;

    // R10 disabled line has no effect
    setup(1, 0, 0, 1, 6, 1, 3);
    wr(3'd4, 16'd1);
    while (count != 16'd2) @(negedge clk);
    fire(2);
    chk(count == 5, "R10 disabled line ignored", int'(count), 5);
    trig_in = '0;

    // R12 self-clear and hold
    setup(1, 0, 0, 0, 6, 1, 3);
    chk(trig_en == 3'b110, "R12 self clear", int'(trig_en), 6);
    wr(3'd3, ctlw(1, 0, 0, 1, 1'b0));
    repeat (3) @(negedge clk);
    fire(1);
    chk(trig_en == 3'b110, "R12 hold keeps", int'(trig_en), 6);
    trig_in = '0;
    wr(3'd4, 16'd0);
    chk(trig_en == 0, "R12 write clears", int'(trig_en), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule